// File: doc/BRIEF.md
# Polled SPI Master with Register Interface

This block is an SPI master that a processor controls by polling three registers: a control and status word, a data port in front of a transmit and a receive FIFO, and a clock divider. Software raises a transfer-active bit, which pulls slave select low. It then waits until the status word shows room in the transmit FIFO and writes a byte to the data port. It reads back the byte that was clocked in during that exchange, and waits for the done flag before it clears transfer-active to release the slave.

The shift engine drives SCLK and MOSI and samples MISO, one 8-bit frame at a time, most significant bit first. Two control bits set the SCLK idle level and select which SCLK edge samples the data. The slave never acknowledges anything: when the transmit FIFO runs dry, SCLK simply stops at its idle level. The engine does not start a new frame while the receive FIFO is full, so no received byte is lost if software falls behind.

Register map (8-bit data bus, 2-bit address): address 0 is control/status, address 1 is the data port, address 2 is the divider, and address 3 reads as zero.

Top module: `spi_poll_master`

## Requirements
- R1: Each frame carries 8 bits, MSB first, in both directions at once. The byte the slave shifts out on MISO is the byte software later reads from the data port, and the byte written to the data port is what the slave sees on MOSI.
- R2: Control bit 0 (transfer-active) drives slave select: `ss_n` is low in the cycle after a write that sets it and high in the cycle after a write that clears it. Clearing it in the middle of a frame abandons that frame, returns SCLK to its idle level and pushes nothing into the receive FIFO.
- R3: Status bit 4 (TX space) is 1 exactly when the transmit FIFO holds fewer than DEPTH bytes (default 4).
- R4: A write to address 1 queues a transmit byte. A read of address 1 returns the oldest received byte and removes it. A read with the receive FIFO empty returns 0.
- R5: Status bit 6 (done) is 1 when the transmit FIFO is empty and no frame is being shifted.
- R6: A write to address 1 while the transmit FIFO is full is dropped: that byte is never sent.
- R7: Control bit 1 (polarity) is the SCLK idle level. Control bit 2 (phase) selects the sampling edge: 0 samples on the first SCLK edge of a bit, 1 on the second. All four combinations exchange bytes correctly with a slave of the same mode.
- R8: The SCLK half-period equals the divider register (address 2) in system clocks. A divider of 0 gives 256 clocks.
- R9: With no data queued, SCLK stays at its idle level and does not toggle, even while slave select is low.
- R10: Writes to the polarity and phase bits take effect only while transfer-active is 0. While it is 1, those bits keep their values.
- R11: Status bit 5 (RX available) is 1 while the receive FIFO holds data. While the receive FIFO is full, no new frame starts, and the engine resumes once a byte is read.
- R12: After reset, `ss_n` is 1, SCLK is 0, control reads 0, the status bits read TX space = 1, done = 1, RX available = 0, and the divider reads its reset value (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe; a read of address 1 pops the receive FIFO |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 1 | Slave select, active low |

## Verification
A wrong FIFO pointer or occupancy shows up at the ports as a status flag that disagrees with the number of bytes written and read. It can also show up as a byte read back out of order, within the same register access or the next frame. A wrong bit or edge counter shows as a shifted or truncated byte at the slave model and on readback, one frame later, or as SCLK toggling, or stopping, at the wrong level. A divider off by one shows as an SCLK half-period that differs from the programmed value on the first edge measured.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam int FRAME_BITS = 8;

   typedef enum logic [1:0] {
      ADDR_CTRL = 2'd0,
      ADDR_DATA = 2'd1,
      ADDR_DIV  = 2'd2,
      ADDR_NONE = 2'd3
   } spim_addr_e;

   localparam int CTL_ACTIVE = 0;
   localparam int CTL_CPOL   = 1;
   localparam int CTL_CPHA   = 2;
   localparam int ST_TXSPACE = 4;
   localparam int ST_RXAVAIL = 5;
   localparam int ST_DONE    = 6;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spim_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW:0]   wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
   assign empty   = (wr_ptr == rd_ptr);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr[AW-1:0]] <= wdata;
   end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
   parameter int FRAME = 8,
   parameter int DIVW  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             cpol,
   input  logic             cpha,
   input  logic [DIVW-1:0]  div,
   input  logic             tx_valid,
   input  logic [FRAME-1:0] tx_data,
   output logic             tx_pop,
   input  logic             rx_ready,
   output logic             rx_push,
   output logic [FRAME-1:0] rx_data,
   output logic             busy,
   output logic             sclk,
   output logic             mosi,
   input  logic             miso
);
   localparam int EDGES = 2 * FRAME;
   localparam int IW    = $clog2(EDGES);
   localparam logic [IW-1:0] LAST = IW'(EDGES - 1);

   if (FRAME < 2) begin : g_bad_frame
      $error("spim_shifter: FRAME must be at least 2");
   end

   logic             busy_q, sclk_q, mosi_q;
   logic [DIVW-1:0]  cnt_q, reload;
   logic [IW-1:0]    idx_q;
   logic [FRAME-1:0] sh_q, rx_q, rx_nx;
   logic             start, tick, sample_now, last;

   assign reload     = div - 1'b1;
   assign start      = en && !busy_q && tx_valid && rx_ready;
   assign tick       = busy_q && (cnt_q == '0);
   assign sample_now = (idx_q[0] == cpha);
   assign last       = (idx_q == LAST);
   assign rx_nx      = {rx_q[FRAME-2:0], miso};

   assign tx_pop  = start;
   assign rx_push = tick && last;
   assign rx_data = sample_now ? rx_nx : rx_q;
   assign busy    = busy_q;
   assign sclk    = busy_q ? sclk_q : cpol;
   assign mosi    = mosi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         mosi_q <= 1'b0;
         cnt_q  <= '0;
         idx_q  <= '0;
         sh_q   <= '0;
         rx_q   <= '0;
      end else if (!en) begin
         busy_q <= 1'b0;
         sclk_q <= cpol;
      end else if (start) begin
         busy_q <= 1'b1;
         sclk_q <= cpol;
         cnt_q  <= reload;
         idx_q  <= '0;
         if (!cpha) begin
            mosi_q <= tx_data[FRAME-1];
            sh_q   <= {tx_data[FRAME-2:0], 1'b0};
         end else begin
            sh_q   <= tx_data;
         end
      end else if (busy_q) begin
         if (!tick) begin
            cnt_q <= cnt_q - 1'b1;
         end else begin
            cnt_q  <= reload;
            sclk_q <= !sclk_q;
            idx_q  <= idx_q + 1'b1;
            if (sample_now) begin
               rx_q <= rx_nx;
            end else if (!last) begin
               mosi_q <= sh_q[FRAME-1];
               sh_q   <= {sh_q[FRAME-2:0], 1'b0};
            end
            if (last) busy_q <= 1'b0;
         end
      end else begin
         sclk_q <= cpol;
      end
   end
endmodule

// File: rtl/spi_poll_master.sv
module spi_poll_master
   import spim_pkg::*;
#(
   parameter int DEPTH     = 4,
   parameter int DIVW      = 8,
   parameter int DIV_RESET = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [1:0]            bus_addr,
   input  logic [FRAME_BITS-1:0] bus_wdata,
   output logic [FRAME_BITS-1:0] bus_rdata,
   output logic                  sclk,
   output logic                  mosi,
   input  logic                  miso,
   output logic                  ss_n
);
   if (DIVW < 1 || DIVW > FRAME_BITS) begin : g_bad_divw
      $error("spi_poll_master: DIVW must lie between 1 and the bus width");
   end

   logic                  active_q, cpol_q, cpha_q;
   logic [DIVW-1:0]       div_q;
   logic                  wr_ctrl, wr_data, wr_div, rd_data;
   logic                  tx_full, tx_empty, rx_full, rx_empty;
   logic                  tx_pop, rx_push, busy, done_w;
   logic [FRAME_BITS-1:0] tx_head, rx_head, rx_word, div_word, ctrl_word;

   assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
   assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
   assign wr_div  = bus_wr && (bus_addr == ADDR_DIV);
   assign rd_data = bus_rd && (bus_addr == ADDR_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cpol_q   <= 1'b0;
         cpha_q   <= 1'b0;
         div_q    <= DIVW'(DIV_RESET);
      end else begin
         if (wr_ctrl) begin
            active_q <= bus_wdata[CTL_ACTIVE];
            if (!active_q) begin
               cpol_q <= bus_wdata[CTL_CPOL];
               cpha_q <= bus_wdata[CTL_CPHA];
            end
         end
         if (wr_div) div_q <= bus_wdata[DIVW-1:0];
      end
   end

   spim_fifo #(.W(FRAME_BITS), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(wr_data), .wdata(bus_wdata),
      .pop(tx_pop), .rdata(tx_head),
      .full(tx_full), .empty(tx_empty)
   );

   spim_fifo #(.W(FRAME_BITS), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .wdata(rx_word),
      .pop(rd_data), .rdata(rx_head),
      .full(rx_full), .empty(rx_empty)
   );

   spim_shifter #(.FRAME(FRAME_BITS), .DIVW(DIVW)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .en(active_q), .cpol(cpol_q), .cpha(cpha_q), .div(div_q),
      .tx_valid(!tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
      .rx_ready(!rx_full), .rx_push(rx_push), .rx_data(rx_word),
      .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso)
   );

   if (DIVW == FRAME_BITS) begin : g_div_full
      assign div_word = div_q;
   end else begin : g_div_pad
      assign div_word = {{(FRAME_BITS-DIVW){1'b0}}, div_q};
   end

   assign done_w = tx_empty && !busy;
   assign ss_n   = !active_q;

   always_comb begin
      ctrl_word             = '0;
      ctrl_word[CTL_ACTIVE] = active_q;
      ctrl_word[CTL_CPOL]   = cpol_q;
      ctrl_word[CTL_CPHA]   = cpha_q;
      ctrl_word[ST_TXSPACE] = !tx_full;
      ctrl_word[ST_RXAVAIL] = !rx_empty;
      ctrl_word[ST_DONE]    = done_w;
      case (bus_addr)
         ADDR_CTRL: bus_rdata = ctrl_word;
         ADDR_DATA: bus_rdata = rx_empty ? '0 : rx_head;
         ADDR_DIV:  bus_rdata = div_word;
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spim_checker.sv
module spim_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_wr,
   input logic [1:0] bus_addr,
   input logic [7:0] bus_wdata,
   input logic       ss_n,
   input logic       sclk,
   input logic       cpol_q,
   input logic       cpha_q,
   input logic       tx_full,
   input logic       rx_full,
   input logic       done
);
   // R2: setting transfer-active selects the slave on the next cycle
   a_r2_select_on_set: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd0 && bus_wdata[0]) |=> !ss_n);

   // R2: clearing transfer-active releases the slave on the next cycle
   a_r2_release_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd0 && !bus_wdata[0]) |=> ss_n);

   // R10: mode bits hold while the slave stays selected
   a_r10_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (!ss_n && $past(!ss_n)) |-> ($stable(cpol_q) && $stable(cpha_q)));

   // R9: with nothing left to send, SCLK is quiet at the idle level
   a_r9_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> (sclk == cpol_q));

   // R6: a data write into a full, idle transmit queue leaves it full
   a_r6_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_full && ss_n && bus_wr && bus_addr == 2'd1) |=> tx_full);

   // R11: a full receive queue cannot coincide with an idle finished engine losing data
   a_r11_rx_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && done && $past(rx_full)) |-> $stable(sclk));
endmodule

bind spi_poll_master spim_checker u_chk (
   .clk(clk), .rst_n(rst_n),
   .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .ss_n(ss_n), .sclk(sclk),
   .cpol_q(cpol_q), .cpha_q(cpha_q),
   .tx_full(tx_full), .rx_full(rx_full), .done(done_w)
);

// File: tb/sim_spi_poll_master.sv
`timescale 1ns/100ps
module sim_spi_poll_master;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       sclk, mosi, ss_n;
   logic       miso = 1'b0;

   int n_checks = 0, n_fail = 0, cyc = 0;
   int k_tx = 0, k_sl = 0;
   logic b_cpha = 1'b0;

   always #2.5 clk = !clk;

   spi_poll_master u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
   );

   function automatic logic [7:0] spat(int k);
      return 8'((k * 29) ^ 8'h5A);
   endfunction
   function automatic logic [7:0] mpat(int k);
      return 8'((k * 53) ^ 8'hC3);
   endfunction

   // slave model: one process, tracks ss_n and SCLK changes itself
   logic       ss_prev = 1'b1, sclk_prev = 1'b0;
   logic [7:0] s_out = 8'd0, s_in = 8'd0;
   int         s_edge = 0, s_cnt = 0, s_nrx = 0;
   logic [7:0] slv_rx [256];

   always @(ss_n or sclk) begin
      if (ss_n !== ss_prev) begin
         ss_prev = ss_n;
         if (ss_n === 1'b0) begin
            s_edge = 0;
            s_out  = spat(s_cnt);
            if (!b_cpha) begin miso = s_out[7]; s_out = {s_out[6:0], 1'b0}; end
         end
      end
      if (sclk !== sclk_prev) begin
         sclk_prev = sclk;
         if (ss_n === 1'b0) begin
            if ((s_edge % 2) == int'(b_cpha)) s_in = {s_in[6:0], mosi};
            else if (b_cpha || s_edge != 15) begin
               miso = s_out[7]; s_out = {s_out[6:0], 1'b0};
            end
            if (s_edge == 15) begin
               slv_rx[s_nrx % 256] = s_in;
               s_nrx  = s_nrx + 1;
               s_cnt  = s_cnt + 1;
               s_edge = 0;
               s_out  = spat(s_cnt);
               if (!b_cpha) begin miso = s_out[7]; s_out = {s_out[6:0], 1'b0}; end
            end else s_edge = s_edge + 1;
         end
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail + 1);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic poll(input int bitn, input string tag);
      logic [7:0] v;
      for (int i = 0; i < 20000; i++) begin
         rd(2'd0, v);
         if (v[bitn]) return;
      end
      chk(1'b0, tag, 0, 1);
   endtask

   task automatic wait_clks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk(ss_n === 1'b1, "R12 ss_n after reset", ss_n, 1);
      chk(sclk === 1'b0, "R12 sclk after reset", sclk, 0);
      rd(2'd0, v); chk(v === 8'h50, "R12 control/status after reset", v, 8'h50);
      rd(2'd2, v); chk(v === 8'd4, "R12 divider after reset", v, 4);
      rd(2'd1, v); chk(v === 8'd0, "R4 empty data read", v, 0);
   endtask

   task automatic t_xfer(input logic pol, input logic pha, input logic [7:0] dv, input int n);
      logic [7:0] v;
      int base;
      wr(2'd0, {5'd0, pha, pol, 1'b0});
      b_cpha = pha;
      wr(2'd2, dv);
      base = s_nrx;
      wr(2'd0, {5'd0, pha, pol, 1'b1});
      chk(ss_n === 1'b0, "R2 select asserted", ss_n, 0);
      chk(sclk === pol, "R9 idle sclk with nothing queued", sclk, pol);
      for (int i = 0; i < n; i++) begin
         poll(4, "R3 tx space poll");
         wr(2'd1, mpat(k_tx + i));
         poll(5, "R11 rx available poll");
         rd(2'd1, v);
         chk(v === spat(k_sl), "R1 R7 master received byte", v, spat(k_sl));
         k_sl++;
      end
      poll(6, "R5 done poll");
      chk(sclk === pol, "R7 sclk back at idle level", sclk, pol);
      chk(s_nrx - base == n, "R1 slave frame count", s_nrx - base, n);
      for (int i = 0; i < n; i++)
         chk(slv_rx[(base + i) % 256] === mpat(k_tx + i), "R1 R7 slave received byte",
             slv_rx[(base + i) % 256], mpat(k_tx + i));
      k_tx += n;
      wr(2'd0, {5'd0, pha, pol, 1'b0});
      chk(ss_n === 1'b1, "R2 select released", ss_n, 1);
   endtask

   task automatic t_halfperiod(input logic [7:0] dv, input int exp);
      logic [7:0] v;
      int cnt, guard;
      b_cpha = 1'b0;
      wr(2'd0, 8'h00);
      wr(2'd2, dv);
      wr(2'd0, 8'h01);
      wr(2'd1, mpat(k_tx));
      guard = 0;
      while (sclk !== 1'b1 && guard < 1000) begin @(negedge clk); guard++; end
      cnt = 0;
      while (sclk === 1'b1 && cnt < 1000) begin @(negedge clk); cnt++; end
      chk(cnt == exp, "R8 sclk half-period", cnt, exp);
      poll(6, "R5 done poll");
      rd(2'd1, v);
      chk(v === spat(k_sl), "R8 byte at this rate", v, spat(k_sl));
      k_sl++; k_tx++;
      wr(2'd0, 8'h00);
   endtask

   task automatic t_mode_lock();
      logic [7:0] v;
      b_cpha = 1'b0;
      wr(2'd0, 8'h01);
      wr(2'd0, 8'h07);
      rd(2'd0, v);
      chk(v[2:0] === 3'b001, "R10 mode bits unchanged while active", v[2:0], 1);
      chk(sclk === 1'b0, "R10 sclk idle level unchanged", sclk, 0);
      wr(2'd0, 8'h00);
      wr(2'd0, 8'h06);
      rd(2'd0, v);
      chk(v[2:0] === 3'b110, "R10 mode bits accepted while inactive", v[2:0], 6);
      chk(sclk === 1'b1, "R7 idle level follows polarity", sclk, 1);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_abort();
      logic [7:0] v;
      b_cpha = 1'b0;
      wr(2'd2, 8'd20);
      wr(2'd0, 8'h01);
      wr(2'd1, mpat(k_tx));
      wait_clks(50);
      wr(2'd0, 8'h00);
      chk(ss_n === 1'b1, "R2 abort releases select", ss_n, 1);
      chk(sclk === 1'b0, "R2 abort returns sclk to idle", sclk, 0);
      rd(2'd0, v);
      chk(v[6] === 1'b1, "R2 R5 done after abort", v[6], 1);
      chk(v[5] === 1'b0, "R2 no byte received after abort", v[5], 0);
      k_tx++;
   endtask

   task automatic t_full();
      logic [7:0] v;
      int base;
      b_cpha = 1'b0;
      wr(2'd0, 8'h00);
      wr(2'd2, 8'd1);
      for (int i = 0; i < 4; i++) wr(2'd1, mpat(k_tx + i));
      rd(2'd0, v);
      chk(v[4] === 1'b0, "R3 no tx space when full", v[4], 0);
      chk(v[6] === 1'b0, "R5 not done with bytes queued", v[6], 0);
      wr(2'd1, 8'hEE);
      base = s_nrx;
      wr(2'd0, 8'h01);
      poll(6, "R5 done poll");
      chk(s_nrx - base == 4, "R6 dropped write not sent", s_nrx - base, 4);
      rd(2'd0, v);
      chk(v[4] === 1'b1, "R3 tx space after drain", v[4], 1);
      wr(2'd1, mpat(k_tx + 4));
      wait_clks(40);
      chk(s_nrx - base == 4, "R11 frame held while rx full", s_nrx - base, 4);
      rd(2'd0, v);
      chk(v[6] === 1'b0, "R11 R5 not done while held", v[6], 0);
      for (int i = 0; i < 5; i++) begin
         poll(5, "R11 rx available poll");
         rd(2'd1, v);
         chk(v === spat(k_sl), "R4 R11 rx order", v, spat(k_sl));
         k_sl++;
      end
      poll(6, "R5 done poll");
      for (int i = 0; i < 5; i++)
         chk(slv_rx[(base + i) % 256] === mpat(k_tx + i), "R6 slave saw queued bytes only",
             slv_rx[(base + i) % 256], mpat(k_tx + i));
      rd(2'd1, v);
      chk(v === 8'd0, "R4 empty data read", v, 0);
      k_tx += 5;
      wr(2'd0, 8'h00);
   endtask

   initial begin
      wait_clks(3);
      rst_n = 1'b1;
      wait_clks(2);
      t_reset();
      t_xfer(1'b0, 1'b0, 8'd1, 3);
      t_xfer(1'b0, 1'b1, 8'd2, 3);
      t_xfer(1'b1, 1'b0, 8'd3, 2);
      t_xfer(1'b1, 1'b1, 8'd1, 3);
      t_halfperiod(8'd3, 3);
      t_halfperiod(8'd0, 256);
      t_mode_lock();
      t_abort();
      t_full();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule